// File: doc/BRIEF.md
# Parallel CRC-32 Frame Checker

This block checks frames that carry their own 32-bit cyclic redundancy code at the end. It absorbs one 16-bit word per valid clock cycle, so a frame takes one sixteenth of the cycles a one-bit-per-clock checker would need. The update is a single XOR network built from two constant matrices. The first matrix maps the 16 incoming data bits onto the next remainder. The second maps the 32 current remainder bits onto the next remainder. Both matrices are computed at elaboration time from the generator polynomial, so no unrolled shift chain appears in the logic.

A frame opens with a start-of-frame pulse, which clears the remainder to zero. It closes with the word that carries the end-of-frame marker. One cycle later the block reports the result. The frame is good when the remainder left after the appended code is zero. No preset, bit reflection or final inversion is applied.

A two-state controller sequences the checker. In `ST_IDLE` no frame is open. In `ST_FRAME` words are being absorbed. A start pulse moves the controller from either state into `ST_FRAME`, or keeps it in `ST_IDLE` when the same word also closes the frame. A valid word with the end marker moves it from `ST_FRAME` back to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `crc32_frame_checker`

## Requirements
- R1: The generator polynomial is 0x04C11DB7 (the x^32 term is implicit). An absorbed word gives the same remainder as 16 single-bit steps, taken from bit 15 down to bit 0. In each step the feedback is remainder bit 31 XOR the data bit, the remainder shifts left by one, and the polynomial is XORed in when the feedback is 1.
- R2: While reset is high, and in the cycle after it, `remainder_o` is zero and `result_valid_o` and `pass_o` are low.
- R3: `sof_i` clears the remainder to zero. If `valid_i` is high in the same cycle, the word is absorbed starting from a zero remainder.
- R4: A cycle with `valid_i` low and `sof_i` low leaves `remainder_o` unchanged, even when `eof_i` is high, and gives no result pulse.
- R5: A valid word without `sof_i` while no frame is open is ignored. `remainder_o` stays unchanged and no result is produced.
- R6: The cycle after a valid word with `eof_i` is absorbed, `result_valid_o` is high for exactly that one cycle. In that cycle `pass_o` is 1 exactly when `remainder_o` is zero.
- R7: A message followed by its own CRC (upper half in the first word, lower half in the second) leaves a zero remainder and `pass_o`=1. Flipping any single bit of such a frame leaves a nonzero remainder and `pass_o`=0.
- R8: `sof_i` during an open frame drops the partial remainder and starts a new frame.
- R9: `pass_o` keeps its value until the next result or the next `sof_i` cycle that does not also close a frame. Such a `sof_i` cycle clears `pass_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sof_i | input | 1 | Start of frame: clears the remainder |
| valid_i | input | 1 | Data word strobe |
| data_i | input | 16 | Data word, bit 15 absorbed first |
| eof_i | input | 1 | Marks the valid word as the last one of the frame |
| remainder_o | output | 32 | Current remainder |
| result_valid_o | output | 1 | One-cycle pulse when a frame result is ready |
| pass_o | output | 1 | Frame result: 1 when the final remainder is zero |

## Verification
The hardest case to reach is the full single-bit-error property. It asks that every possible error position inside a good frame, including positions inside the appended code, leaves a nonzero residue. The bench builds a good frame by computing its code with an independent bit-serial loop. It then replays the frame once for each of its 96 bit positions with that one bit inverted. The word update itself is swept over all 65536 data values from a cleared state, and along a long chain that starts from a nonzero remainder.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
    localparam int          CRC_W  = 32;
    localparam int          WORD_W = 16;
    localparam logic [31:0] GEN_POLY = 32'h04C1_1DB7;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } chk_state_e;
endpackage

// File: rtl/crc_xor_net.sv
module crc_xor_net #(
    parameter int          CRC_W  = 32,
    parameter int          WORD_W = 16,
    parameter logic [31:0] POLY   = 32'h04C1_1DB7
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [CRC_W-1:0]  state_i,
    output logic [CRC_W-1:0]  next_o
);
    typedef logic [WORD_W-1:0][CRC_W-1:0] dmat_t;
    typedef logic [CRC_W-1:0][CRC_W-1:0]  smat_t;

    // One serial step per data bit, highest bit first.
    function automatic logic [CRC_W-1:0] serial_steps(input logic [CRC_W-1:0] c_in,
                                                      input logic [WORD_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = c << 1;
            if (fb) c = c ^ POLY[CRC_W-1:0];
        end
        return c;
    endfunction

    function automatic dmat_t build_dmat();
        dmat_t m;
        for (int j = 0; j < WORD_W; j++)
            m[j] = serial_steps('0, WORD_W'(1) << j);
        return m;
    endfunction

    function automatic smat_t build_smat();
        smat_t m;
        for (int j = 0; j < CRC_W; j++)
            m[j] = serial_steps(CRC_W'(1) << j, '0);
        return m;
    endfunction

    localparam dmat_t DMAT = build_dmat();
    localparam smat_t SMAT = build_smat();

    for (genvar k = 0; k < CRC_W; k++) begin : g_out
        logic [WORD_W-1:0] dsel;
        logic [CRC_W-1:0]  ssel;
        for (genvar j = 0; j < WORD_W; j++) begin : g_d
            assign dsel[j] = word_i[j] & DMAT[j][k];
        end
        for (genvar j = 0; j < CRC_W; j++) begin : g_s
            assign ssel[j] = state_i[j] & SMAT[j][k];
        end
        assign next_o[k] = (^dsel) ^ (^ssel);
    end
endmodule

// File: rtl/crc_frame_fsm.sv
module crc_frame_fsm
    import crc_chk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sof_i,
    input  logic       valid_i,
    input  logic       eof_i,
    output logic       clear_o,
    output logic       absorb_o,
    output logic       finish_o,
    output chk_state_e state_o
);
    chk_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_i && !(valid_i && eof_i)) state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (valid_i && eof_i)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clear_o  = sof_i;
        absorb_o = valid_i && (sof_i || state_q == ST_FRAME);
        finish_o = absorb_o && eof_i;
        state_o  = state_q;
    end
endmodule

// File: rtl/crc32_frame_checker.sv
module crc32_frame_checker
    import crc_chk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sof_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              eof_i,
    output logic [CRC_W-1:0]  remainder_o,
    output logic              result_valid_o,
    output logic              pass_o
);
    logic             clear, absorb, finish;
    chk_state_e       frm_state;
    logic [CRC_W-1:0] rem_q, net_in, net_out;
    logic             rv_q, pass_q;

    crc_frame_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .sof_i    (sof_i),
        .valid_i  (valid_i),
        .eof_i    (eof_i),
        .clear_o  (clear),
        .absorb_o (absorb),
        .finish_o (finish),
        .state_o  (frm_state)
    );

    assign net_in = clear ? '0 : rem_q;

    crc_xor_net #(
        .CRC_W  (CRC_W),
        .WORD_W (WORD_W),
        .POLY   (GEN_POLY)
    ) u_net (
        .word_i  (data_i),
        .state_i (net_in),
        .next_o  (net_out)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rem_q  <= '0;
            rv_q   <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            if (absorb)     rem_q <= net_out;
            else if (clear) rem_q <= '0;
            rv_q <= finish;
            if (finish)     pass_q <= (net_out == '0);
            else if (clear) pass_q <= 1'b0;
        end
    end

    assign remainder_o    = rem_q;
    assign result_valid_o = rv_q;
    assign pass_o         = pass_q;
endmodule

// File: rtl/crc32_chk_sva.sv
module crc32_chk_sva
    import crc_chk_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              sof_i,
    input logic              valid_i,
    input logic              eof_i,
    input logic [CRC_W-1:0]  remainder_o,
    input logic              result_valid_o,
    input logic              pass_o,
    input chk_state_e        state_i
);
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (remainder_o == '0 && !pass_o && !result_valid_o)); // R2

    AST_SOF_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (sof_i && !valid_i) |=> (remainder_o == '0)); // R3

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sof_i && !valid_i) |=> ($stable(remainder_o) && !result_valid_o)); // R4

    AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_IDLE && valid_i && !sof_i) |=> ($stable(remainder_o) && !result_valid_o)); // R5

    AST_RESULT_TIMING: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && eof_i && (sof_i || state_i == ST_FRAME)) |=> result_valid_o); // R6

    AST_PASS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        result_valid_o |-> (pass_o == (remainder_o == '0))); // R6

    AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sof_i && !(valid_i && eof_i)) |=> $stable(pass_o)); // R9
endmodule

bind crc32_frame_checker crc32_chk_sva u_sva (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .sof_i          (sof_i),
    .valid_i        (valid_i),
    .eof_i          (eof_i),
    .remainder_o    (remainder_o),
    .result_valid_o (result_valid_o),
    .pass_o         (pass_o),
    .state_i        (frm_state)
);

// File: tb/crc32_frame_checker_tb_top.sv
module crc32_frame_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst, sof, valid, eof;
    logic [15:0] data;
    logic [31:0] remainder;
    logic        rv, pass;

    int checks = 0;
    int failures = 0;

    logic [15:0] fw [0:5];
    logic [31:0] exp_rem;

    always #10 clk = ~clk;

    crc32_frame_checker dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .sof_i          (sof),
        .valid_i        (valid),
        .data_i         (data),
        .eof_i          (eof),
        .remainder_o    (remainder),
        .result_valid_o (rv),
        .pass_o         (pass)
    );

    function automatic logic [31:0] ser16(input logic [31:0] c_in, input logic [15:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 15; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic cyc(input logic s, input logic v, input logic [15:0] d, input logic e);
        sof = s; valid = v; data = d; eof = e;
        @(posedge clk);
        #5;
    endtask

    // Sends fw[0..5]; fw[4], fw[5] carry the code.
    task automatic send_frame();
        for (int i = 0; i < 6; i++)
            cyc(i == 0, 1'b1, fw[i], i == 5);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] c;
        logic [31:0] held;
        logic [15:0] w;
        rst = 1'b1; sof = 0; valid = 0; data = 0; eof = 0;
        @(posedge clk); #5;
        cyc(0, 0, 16'h0, 0);
        chk(remainder == 0 && !rv && !pass, "R2 reset state", {29'b0, rv, pass, |remainder}, 32'h0);
        rst = 1'b0;
        cyc(0, 0, 16'h0, 0);
        chk(remainder == 0 && !rv && !pass, "R2 after reset", remainder, 32'h0);

        // R1 / R3: every word from a cleared state (sof with valid)
        for (int v = 0; v < 65536; v++) begin
            cyc(1, 1, 16'(v), 0);
            exp_rem = ser16(32'h0, 16'(v));
            chk(remainder == exp_rem, "R1 R3 word from zero", remainder, exp_rem);
        end

        // R1: chained updates from a nonzero state
        exp_rem = ser16(32'h0, 16'hFFFF);
        w = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
            cyc(0, 1, w, 0);
            exp_rem = ser16(exp_rem, w);
            chk(remainder == exp_rem, "R1 chained word", remainder, exp_rem);
        end

        // R4: stall, including eof without valid
        held = remainder;
        cyc(0, 0, 16'h5A5A, 0);
        chk(remainder == held && !rv, "R4 stall", remainder, held);
        cyc(0, 0, 16'h1234, 1);
        chk(remainder == held && !rv, "R4 eof without valid", remainder, held);

        // R8: sof in an open frame restarts
        cyc(1, 1, 16'hBEEF, 0);
        exp_rem = ser16(32'h0, 16'hBEEF);
        chk(remainder == exp_rem, "R8 restart", remainder, exp_rem);

        // R3: sof alone clears
        cyc(1, 0, 16'h7777, 0);
        chk(remainder == 0, "R3 sof clears", remainder, 32'h0);

        // R7 / R6: good frame
        fw[0] = 16'h1234; fw[1] = 16'h5678; fw[2] = 16'h9ABC; fw[3] = 16'hDEF0;
        c = 32'h0;
        for (int i = 0; i < 4; i++) c = ser16(c, fw[i]);
        fw[4] = c[31:16]; fw[5] = c[15:0];
        send_frame();
        chk(rv == 1'b1, "R6 result pulse", {31'b0, rv}, 32'h1);
        chk(remainder == 0, "R7 good residue", remainder, 32'h0);
        chk(pass == 1'b1, "R7 good pass", {31'b0, pass}, 32'h1);
        cyc(0, 0, 16'h0, 0);
        chk(rv == 1'b0, "R6 pulse one cycle", {31'b0, rv}, 32'h0);
        chk(pass == 1'b1, "R9 pass held", {31'b0, pass}, 32'h1);

        // R5: valid word with no frame open is ignored
        cyc(0, 1, 16'hABCD, 0);
        chk(remainder == 0 && !rv, "R5 idle ignore", remainder, 32'h0);
        cyc(0, 1, 16'hABCD, 1);
        chk(remainder == 0 && !rv && pass, "R5 idle eof ignore", remainder, 32'h0);

        // R9: sof clears pass
        cyc(1, 0, 16'h0, 0);
        chk(pass == 1'b0, "R9 sof clears pass", {31'b0, pass}, 32'h0);

        // R6: single-word frames
        cyc(1, 1, 16'h0000, 1);
        chk(rv && pass && remainder == 0, "R6 zero single word", remainder, 32'h0);
        cyc(1, 1, 16'h8001, 1);
        exp_rem = ser16(32'h0, 16'h8001);
        chk(rv && !pass && remainder == exp_rem, "R6 nonzero single word", remainder, exp_rem);

        // R7: every single-bit error
        for (int b = 0; b < 96; b++) begin
            fw[b / 16][b % 16] = ~fw[b / 16][b % 16];
            send_frame();
            chk(rv && !pass && remainder != 0, "R7 bit flip", remainder, 32'h0);
            fw[b / 16][b % 16] = ~fw[b / 16][b % 16];
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule